// File: doc/BRIEF.md
# Exception Pending and Status Register Unit

This block is a small register-mapped unit that sits beside an interrupt controller and gives software a word-addressed view of system exception state. Through a control-state register, software can raise the non-maskable exception, raise or withdraw the PendSV and tick exceptions, and read back a live summary. That summary holds the active vector, the lowest-numbered pending vector, an any-external-pending flag and a return-to-base flag. A handler status register reports the pending and active state of the fault, call and debug exceptions and holds the three fault handler enables. A trigger register lets software pend an external interrupt by number, and a type register reports how many external interrupts are implemented.

The unit does not store pending or active state itself. The controller supplies those bits as inputs, and the unit answers register writes with single-cycle set and clear strobes, one per system exception, and with a trigger strobe that carries an interrupt number. Priority arbitration and vector fetch belong to the surrounding controller. Within this block, vectors are ordered by number alone, so the lowest number is the one reported.

Top module: `epsr_unit`

## Requirements
- R1: After synchronous reset, set_pend_o, clr_pend_o, trig_o and fault_en_o are all zero. Strobe vectors are indexed NMI=0, mem fault=1, bus fault=2, usage fault=3, SVC=4, debug=5, PendSV=6, tick=7.
- R2: A write to word offset 0 with bit 31 set pulses set_pend_o[0] (NMI).
- R3: In a write to offset 0, bit 28 pulses set_pend_o[6] (PendSV). Bit 27 pulses clr_pend_o[6], but only when bit 28 is clear in the same write.
- R4: In a write to offset 0, bit 26 pulses set_pend_o[7] (tick). Bit 25 pulses clr_pend_o[7], but only when bit 26 is clear in the same write.
- R5: Every strobe is high for exactly the one cycle after the clock edge that accepts the write, and is low again in the next cycle unless another write arrives.
- R6: A read of offset 0 returns cur_vec_i in bits [8:0]. Bits [20:12] hold the lowest-numbered pending vector, and are zero when nothing is pending. System exceptions use vectors NMI 2, mem 4, bus 5, usage 6, SVC 11, debug 12, PendSV 14 and tick 15; external interrupt n is vector 16+n.
- R7: A read of offset 0 returns tick pending in bit 26, PendSV pending in bit 28 and NMI pending in bit 31. Bit 22 is set when any external interrupt is pending.
- R8: Bit 11 of offset 0 is set exactly when no exception or interrupt is active other than the one whose vector equals cur_vec_i.
- R9: A read of offset 1 returns the active bits of mem, bus, usage, SVC, debug, PendSV and tick in bits 0, 1, 3, 7, 8, 10 and 11. It returns the pending bits of usage, mem, bus and SVC in bits 12 to 15, and the mem, bus and usage fault enables in bits 16 to 18. All other bits read zero.
- R10: A write to offset 1 loads bits 16, 17 and 18 into the mem, bus and usage fault enables (fault_en_o bits 0, 1, 2), and ignores all other bits. Writes to any other offset leave the enables unchanged.
- R11: A write to offset 2 takes bits [8:0] as an interrupt number. If that number is below NUM_IRQ, trig_o pulses with trig_irq_o equal to it. Otherwise no trigger is issued.
- R12: A read of offset 3 returns NUM_IRQ/32 - 1. A read of any unmapped offset returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | ADDR_W | Word offset of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| sys_pend_i | input | 8 | Pending bits of the system exceptions |
| sys_act_i | input | 8 | Active bits of the system exceptions |
| irq_pend_i | input | NUM_IRQ | Pending bits of the external interrupts |
| irq_act_i | input | NUM_IRQ | Active bits of the external interrupts |
| cur_vec_i | input | 9 | Vector the processor is currently executing |
| set_pend_o | output | 8 | Single-cycle set-pending strobes |
| clr_pend_o | output | 8 | Single-cycle clear-pending strobes |
| trig_o | output | 1 | Software trigger strobe |
| trig_irq_o | output | 9 | Interrupt number carried with trig_o |
| fault_en_o | output | 3 | Mem, bus and usage fault handler enables |

## Verification
The assertions assume that reg_we stays low during reset, so that the fault enables have nothing to be held against in the first cycle after reset. They also assume that reg_addr and reg_wdata are known whenever reg_we is high, and that the pending and active inputs are known once reset is released. The bench drives every input on the falling edge and holds all pending and active inputs at zero through reset. It issues writes as one-cycle pulses and drops reg_we before the next rising edge, so each strobe can be traced to exactly one accepted write.

// File: rtl/epsr_pkg.sv
package epsr_pkg;

    localparam int SYS_N     = 8;
    localparam int VEC_W     = 9;
    localparam int VEC_SPACE = 1 << VEC_W;
    localparam int DATA_W    = 32;
    localparam int IRQ_BASE  = 16;

    typedef enum logic [2:0] {
        EXC_NMI    = 3'd0,
        EXC_MEM    = 3'd1,
        EXC_BUS    = 3'd2,
        EXC_USAGE  = 3'd3,
        EXC_SVC    = 3'd4,
        EXC_DEBUG  = 3'd5,
        EXC_PENDSV = 3'd6,
        EXC_TICK   = 3'd7
    } exc_e;

    // register word offsets
    localparam int REG_CTL  = 0;
    localparam int REG_HST  = 1;
    localparam int REG_TRIG = 2;
    localparam int REG_TYPE = 3;

    // control-state bit positions
    localparam int CS_NMI_SET   = 31;
    localparam int CS_PSV_SET   = 28;
    localparam int CS_PSV_CLR   = 27;
    localparam int CS_TCK_SET   = 26;
    localparam int CS_TCK_CLR   = 25;
    localparam int CS_ISR_PEND  = 22;
    localparam int CS_PVEC_LSB  = 12;
    localparam int CS_RTB       = 11;

    // handler status bit positions
    localparam int HS_ACT_MEM   = 0;
    localparam int HS_ACT_BUS   = 1;
    localparam int HS_ACT_USAGE = 3;
    localparam int HS_ACT_SVC   = 7;
    localparam int HS_ACT_DBG   = 8;
    localparam int HS_ACT_PSV   = 10;
    localparam int HS_ACT_TCK   = 11;
    localparam int HS_PND_USAGE = 12;
    localparam int HS_PND_MEM   = 13;
    localparam int HS_PND_BUS   = 14;
    localparam int HS_PND_SVC   = 15;
    localparam int HS_EN_LSB    = 16;

    typedef struct packed {
        logic [SYS_N-1:0] set;
        logic [SYS_N-1:0] clr;
        logic             trig;
        logic [VEC_W-1:0] num;
    } wr_cmd_t;

    typedef struct packed {
        logic [VEC_W-1:0] pend_vec;
        logic             isr_pend;
        logic             rtb;
    } scan_t;

    function automatic logic [VEC_W-1:0] exc_vec(input int idx);
        case (idx)
            0:       return 9'd2;
            1:       return 9'd4;
            2:       return 9'd5;
            3:       return 9'd6;
            4:       return 9'd11;
            5:       return 9'd12;
            6:       return 9'd14;
            default: return 9'd15;
        endcase
    endfunction

endpackage

// File: rtl/epsr_wr_ctl.sv
module epsr_wr_ctl
    import epsr_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    parameter int ADDR_W  = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    we,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [DATA_W-1:0]       wdata,
    output logic [SYS_N-1:0]        set_pend,
    output logic [SYS_N-1:0]        clr_pend,
    output logic                    trig,
    output logic [VEC_W-1:0]        trig_irq,
    output logic [2:0]              fault_en
);

    wr_cmd_t    cmd_d, cmd_q;
    logic [2:0] fen_d, fen_q;
    logic       hit_ctl, hit_hst, hit_trig;
    logic       num_ok;

    assign hit_ctl  = we && (addr == ADDR_W'(REG_CTL));
    assign hit_hst  = we && (addr == ADDR_W'(REG_HST));
    assign hit_trig = we && (addr == ADDR_W'(REG_TRIG));
    assign num_ok   = (32'(wdata[VEC_W-1:0]) < 32'(NUM_IRQ));

    always_comb begin
        cmd_d = '0;
        fen_d = fen_q;
        if (hit_ctl) begin
            cmd_d.set[EXC_NMI]    = wdata[CS_NMI_SET];
            cmd_d.set[EXC_PENDSV] = wdata[CS_PSV_SET];
            cmd_d.clr[EXC_PENDSV] = wdata[CS_PSV_CLR] & ~wdata[CS_PSV_SET];
            cmd_d.set[EXC_TICK]   = wdata[CS_TCK_SET];
            cmd_d.clr[EXC_TICK]   = wdata[CS_TCK_CLR] & ~wdata[CS_TCK_SET];
        end
        if (hit_hst) begin
            fen_d = wdata[HS_EN_LSB +: 3];
        end
        if (hit_trig && num_ok) begin
            cmd_d.trig = 1'b1;
            cmd_d.num  = wdata[VEC_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
            fen_q <= '0;
        end else begin
            cmd_q <= cmd_d;
            fen_q <= fen_d;
        end
    end

    assign set_pend = cmd_q.set;
    assign clr_pend = cmd_q.clr;
    assign trig     = cmd_q.trig;
    assign trig_irq = cmd_q.num;
    assign fault_en = fen_q;

    // R2: an NMI set strobe traces back to a control write with bit 31
    p_nmi_src_r2: assert property (@(posedge clk) disable iff (rst)
        set_pend[EXC_NMI] |-> $past(we && addr == ADDR_W'(REG_CTL) && wdata[CS_NMI_SET]));

    // R3: PendSV clear never issued when the same write also set it
    p_psv_setwins_r3: assert property (@(posedge clk) disable iff (rst)
        clr_pend[EXC_PENDSV] |-> !$past(wdata[CS_PSV_SET]));

    // R4: tick clear never issued when the same write also set it
    p_tck_setwins_r4: assert property (@(posedge clk) disable iff (rst)
        clr_pend[EXC_TICK] |-> !$past(wdata[CS_TCK_SET]));

    // R5: any strobe follows an accepted write one cycle earlier
    p_strobe_src_r5: assert property (@(posedge clk) disable iff (rst)
        ((set_pend | clr_pend) != '0 || trig) |-> $past(we));

    // R10: fault enables move only after a handler status write
    p_fen_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !$past(we && addr == ADDR_W'(REG_HST)) |-> $stable(fault_en));

    // R11: triggered numbers are always implemented interrupts
    p_trig_range_r11: assert property (@(posedge clk) disable iff (rst)
        trig |-> (32'(trig_irq) < 32'(NUM_IRQ)));

endmodule

// File: rtl/epsr_pend_scan.sv
module epsr_pend_scan
    import epsr_pkg::*;
#(
    parameter int NUM_IRQ = 64
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [SYS_N-1:0]    sys_pend,
    input  logic [SYS_N-1:0]    sys_act,
    input  logic [NUM_IRQ-1:0]  irq_pend,
    input  logic [NUM_IRQ-1:0]  irq_act,
    input  logic [VEC_W-1:0]    cur_vec,
    output scan_t               res
);

    logic [VEC_SPACE-1:0] vp, va;
    logic                 others_act;
    logic [VEC_W-1:0]     pv;

    // map every source onto its vector slot
    always_comb begin
        vp = '0;
        va = '0;
        for (int i = 0; i < SYS_N; i++) begin
            vp[exc_vec(i)] = sys_pend[i];
            va[exc_vec(i)] = sys_act[i];
        end
        vp[IRQ_BASE +: NUM_IRQ] = irq_pend;
        va[IRQ_BASE +: NUM_IRQ] = irq_act;
    end

    // lowest numbered pending vector wins
    always_comb begin
        pv = '0;
        for (int j = VEC_SPACE - 1; j >= 1; j--) begin
            if (vp[j[VEC_W-1:0]]) pv = j[VEC_W-1:0];
        end
    end

    always_comb begin
        others_act = 1'b0;
        for (int j = 1; j < VEC_SPACE; j++) begin
            if (va[j[VEC_W-1:0]] && (j[VEC_W-1:0] != cur_vec)) others_act = 1'b1;
        end
    end

    assign res.pend_vec = pv;
    assign res.isr_pend = |irq_pend;
    assign res.rtb      = ~others_act;

    // R6: a reported vector is really pending
    p_pvec_valid_r6: assert property (@(posedge clk) disable iff (rst)
        (res.pend_vec != '0) |-> vp[res.pend_vec]);

    // R6: something pending means the field is non-zero
    p_pvec_nonzero_r6: assert property (@(posedge clk) disable iff (rst)
        ((sys_pend != '0) || (irq_pend != '0)) |-> (res.pend_vec != '0));

    // R8: if the only active source is the current vector, return-to-base holds
    p_rtb_r8: assert property (@(posedge clk) disable iff (rst)
        (sys_act == '0 && $onehot0(irq_act) && (irq_act == '0 ||
         irq_act[cur_vec - VEC_W'(IRQ_BASE)])) |-> res.rtb);

endmodule

// File: rtl/epsr_rd_mux.sv
module epsr_rd_mux
    import epsr_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    parameter int ADDR_W  = 4
) (
    input  logic [ADDR_W-1:0]   addr,
    input  scan_t               scan,
    input  logic [SYS_N-1:0]    sys_pend,
    input  logic [SYS_N-1:0]    sys_act,
    input  logic [2:0]          fault_en,
    input  logic [VEC_W-1:0]    cur_vec,
    output logic [DATA_W-1:0]   rdata
);

    localparam int TYPE_VAL = NUM_IRQ / 32 - 1;

    logic [DATA_W-1:0] ctl_word, hst_word;

    always_comb begin
        ctl_word                            = '0;
        ctl_word[VEC_W-1:0]                 = cur_vec;
        ctl_word[CS_RTB]                    = scan.rtb;
        ctl_word[CS_PVEC_LSB +: VEC_W]      = scan.pend_vec;
        ctl_word[CS_ISR_PEND]               = scan.isr_pend;
        ctl_word[CS_TCK_SET]                = sys_pend[EXC_TICK];
        ctl_word[CS_PSV_SET]                = sys_pend[EXC_PENDSV];
        ctl_word[CS_NMI_SET]                = sys_pend[EXC_NMI];
    end

    always_comb begin
        hst_word                 = '0;
        hst_word[HS_ACT_MEM]     = sys_act[EXC_MEM];
        hst_word[HS_ACT_BUS]     = sys_act[EXC_BUS];
        hst_word[HS_ACT_USAGE]   = sys_act[EXC_USAGE];
        hst_word[HS_ACT_SVC]     = sys_act[EXC_SVC];
        hst_word[HS_ACT_DBG]     = sys_act[EXC_DEBUG];
        hst_word[HS_ACT_PSV]     = sys_act[EXC_PENDSV];
        hst_word[HS_ACT_TCK]     = sys_act[EXC_TICK];
        hst_word[HS_PND_USAGE]   = sys_pend[EXC_USAGE];
        hst_word[HS_PND_MEM]     = sys_pend[EXC_MEM];
        hst_word[HS_PND_BUS]     = sys_pend[EXC_BUS];
        hst_word[HS_PND_SVC]     = sys_pend[EXC_SVC];
        hst_word[HS_EN_LSB +: 3] = fault_en;
    end

    always_comb begin
        case (addr)
            ADDR_W'(REG_CTL):  rdata = ctl_word;
            ADDR_W'(REG_HST):  rdata = hst_word;
            ADDR_W'(REG_TYPE): rdata = DATA_W'(TYPE_VAL);
            default:           rdata = '0;
        endcase
    end

endmodule

// File: rtl/epsr_unit.sv
module epsr_unit
    import epsr_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    parameter int ADDR_W  = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_we,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    input  logic [7:0]          sys_pend_i,
    input  logic [7:0]          sys_act_i,
    input  logic [NUM_IRQ-1:0]  irq_pend_i,
    input  logic [NUM_IRQ-1:0]  irq_act_i,
    input  logic [8:0]          cur_vec_i,
    output logic [7:0]          set_pend_o,
    output logic [7:0]          clr_pend_o,
    output logic                trig_o,
    output logic [8:0]          trig_irq_o,
    output logic [2:0]          fault_en_o
);

    scan_t      scan;
    logic [2:0] fen;

    epsr_wr_ctl #(.NUM_IRQ(NUM_IRQ), .ADDR_W(ADDR_W)) u_wr (
        .clk      (clk),
        .rst      (rst),
        .we       (reg_we),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .set_pend (set_pend_o),
        .clr_pend (clr_pend_o),
        .trig     (trig_o),
        .trig_irq (trig_irq_o),
        .fault_en (fen)
    );

    epsr_pend_scan #(.NUM_IRQ(NUM_IRQ)) u_scan (
        .clk      (clk),
        .rst      (rst),
        .sys_pend (sys_pend_i),
        .sys_act  (sys_act_i),
        .irq_pend (irq_pend_i),
        .irq_act  (irq_act_i),
        .cur_vec  (cur_vec_i),
        .res      (scan)
    );

    epsr_rd_mux #(.NUM_IRQ(NUM_IRQ), .ADDR_W(ADDR_W)) u_rd (
        .addr     (reg_addr),
        .scan     (scan),
        .sys_pend (sys_pend_i),
        .sys_act  (sys_act_i),
        .fault_en (fen),
        .cur_vec  (cur_vec_i),
        .rdata    (reg_rdata)
    );

    assign fault_en_o = fen;

    // R1: nothing leaves the unit in the first cycle after reset
    p_quiet_after_reset_r1: assert property (@(posedge clk)
        $past(rst) |-> (set_pend_o == '0 && clr_pend_o == '0 && !trig_o));

endmodule

// File: tb/epsr_unit_tb.sv
module epsr_unit_tb;

    localparam int NUM_IRQ = 64;
    localparam int ADDR_W  = 4;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                reg_we = 1'b0;
    logic [ADDR_W-1:0]   reg_addr = '0;
    logic [31:0]         reg_wdata = '0;
    logic [31:0]         reg_rdata;
    logic [7:0]          sys_pend_i = '0;
    logic [7:0]          sys_act_i = '0;
    logic [NUM_IRQ-1:0]  irq_pend_i = '0;
    logic [NUM_IRQ-1:0]  irq_act_i = '0;
    logic [8:0]          cur_vec_i = '0;
    logic [7:0]          set_pend_o, clr_pend_o;
    logic                trig_o;
    logic [8:0]          trig_irq_o;
    logic [2:0]          fault_en_o;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    epsr_unit #(.NUM_IRQ(NUM_IRQ), .ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sys_pend_i(sys_pend_i), .sys_act_i(sys_act_i),
        .irq_pend_i(irq_pend_i), .irq_act_i(irq_act_i), .cur_vec_i(cur_vec_i),
        .set_pend_o(set_pend_o), .clr_pend_o(clr_pend_o),
        .trig_o(trig_o), .trig_irq_o(trig_irq_o), .fault_en_o(fault_en_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // one-cycle write; returns at the falling edge where strobes are visible
    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = ADDR_W'(a); reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = ADDR_W'(a);
        #1 d = reg_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 set_pend after reset", 32'(set_pend_o), 0);
        check("R1 clr_pend after reset", 32'(clr_pend_o), 0);
        check("R1 trig after reset", 32'(trig_o), 0);
        check("R1 fault_en after reset", 32'(fault_en_o), 0);
        rd(1, d);
        check("R9 handler status idle", d, 0);
    endtask

    task automatic t_nmi();
        wr(0, 32'h8000_0000);
        check("R2 nmi set strobe", 32'(set_pend_o), 32'h01);
        check("R2 no clear", 32'(clr_pend_o), 0);
        @(negedge clk);
        check("R5 strobe drops", 32'(set_pend_o), 0);
    endtask

    task automatic t_pendsv();
        wr(0, 32'h1800_0000);
        check("R3 set wins set", 32'(set_pend_o), 32'h40);
        check("R3 set wins clr", 32'(clr_pend_o), 0);
        wr(0, 32'h0800_0000);
        check("R3 clear alone set", 32'(set_pend_o), 0);
        check("R3 clear alone clr", 32'(clr_pend_o), 32'h40);
        @(negedge clk);
        check("R5 clear drops", 32'(clr_pend_o), 0);
    endtask

    task automatic t_tick();
        wr(0, 32'h0600_0000);
        check("R4 set wins set", 32'(set_pend_o), 32'h80);
        check("R4 set wins clr", 32'(clr_pend_o), 0);
        wr(0, 32'h0200_0000);
        check("R4 clear alone", 32'(clr_pend_o), 32'h80);
        wr(0, 32'h9400_0000);
        check("R2 R3 R4 combined sets", 32'(set_pend_o), 32'hC1);
        wr(1, 32'h9E00_0000);
        check("R5 other offset no strobe", 32'(set_pend_o | clr_pend_o), 0);
    endtask

    task automatic t_ctl_read();
        logic [31:0] d;
        sys_pend_i = '0; irq_pend_i = '0; sys_act_i = '0; irq_act_i = '0; cur_vec_i = '0;
        rd(0, d);
        check("R6 nothing pending", d, 32'h0000_0800);
        sys_pend_i = 8'h80;
        rd(0, d);
        check("R7 tick pending vec15", d, 32'h0400_F800);
        irq_pend_i[5] = 1'b1;
        rd(0, d);
        check("R7 isr pending, R6 vec15 still lowest", d, 32'h0440_F800);
        sys_pend_i = 8'h42; irq_pend_i = '0; irq_pend_i[3] = 1'b1;
        rd(0, d);
        check("R6 mem vec4 lowest, R7 pendsv bit", d, 32'h1040_4800);
        sys_pend_i = 8'h01;
        rd(0, d);
        check("R7 nmi bit, R6 vec2", d, 32'h8040_2800);
        sys_pend_i = '0; irq_pend_i = '0; irq_pend_i[40] = 1'b1;
        rd(0, d);
        check("R6 external vec56", d, 32'h0043_8800);
        irq_pend_i = '0;
        cur_vec_i = 9'd21; irq_act_i[5] = 1'b1;
        rd(0, d);
        check("R8 only current active", d, 32'h0000_0815);
        sys_act_i[4] = 1'b1;
        rd(0, d);
        check("R8 svc also active", d, 32'h0000_0015);
        sys_act_i = '0; irq_act_i = '0; irq_act_i[6] = 1'b1;
        rd(0, d);
        check("R8 other irq active", d, 32'h0000_0015);
        irq_act_i = '0; cur_vec_i = '0;
    endtask

    task automatic t_hst();
        logic [31:0] d;
        wr(1, 32'hFFFF_FFFF);
        check("R10 all enables", 32'(fault_en_o), 32'h7);
        sys_act_i = 8'hFF; sys_pend_i = 8'hFF;
        rd(1, d);
        check("R9 full layout", d, 32'h0007_FD8B);
        sys_act_i = 8'h01; sys_pend_i = 8'h01;
        rd(1, d);
        check("R9 nmi not shown", d, 32'h0007_0000);
        sys_act_i = '0; sys_pend_i = '0;
        wr(1, 32'hFFF2_FFFF);
        check("R10 bus only", 32'(fault_en_o), 32'h2);
        rd(1, d);
        check("R9 enable readback", d, 32'h0002_0000);
        wr(3, 32'hFFFF_FFFF);
        wr(0, 32'h0007_0000);
        check("R10 other offsets ignored", 32'(fault_en_o), 32'h2);
    endtask

    task automatic t_trig();
        wr(2, 32'h0000_0005);
        check("R11 trig 5", 32'(trig_o), 1);
        check("R11 num 5", 32'(trig_irq_o), 5);
        wr(2, 32'h0000_003F);
        check("R11 trig top", 32'(trig_o), 1);
        check("R11 num top", 32'(trig_irq_o), 63);
        wr(2, 32'h0000_0040);
        check("R11 at limit ignored", 32'(trig_o), 0);
        wr(2, 32'h0000_01FF);
        check("R11 max ignored", 32'(trig_o), 0);
        wr(2, 32'hFFFF_FE07);
        check("R11 upper bits masked", 32'(trig_o), 1);
        check("R11 masked num", 32'(trig_irq_o), 7);
        @(negedge clk);
        check("R5 trig drops", 32'(trig_o), 0);
    endtask

    task automatic t_type();
        logic [31:0] d;
        rd(3, d);
        check("R12 type value", d, NUM_IRQ / 32 - 1);
        rd(5, d);
        check("R12 unmapped zero", d, 0);
        rd(2, d);
        check("R12 trigger reads zero", d, 0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected<=100000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_nmi();
        t_pendsv();
        t_tick();
        t_ctl_read();
        t_hst();
        t_trig();
        t_type();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule